// File: doc/BRIEF.md
# CAN Low-Power Entry and Bus Wake-Up Controller

This block sits beside a CAN protocol engine and handles its local sleep mode. Software raises a sleep request. The block does not act on it straight away. It waits until the protocol engine reports that the bus is idle, so a frame already in progress always completes. It then raises an acknowledge flag for the status register and drops the clock enable that feeds the engine's clock gate.

While asleep, the block can rouse itself. It watches the raw receive pin through a synchronizer and a short dominant-level filter, using an always-on clock. If bus wake-up is enabled and a dominant level (logic 0) persists long enough, the block does three things:
- it restores the clock enable,
- it clears the acknowledge flag,
- it issues a single-cycle wake event.

The engine was unclocked when that frame began, so the frame is never received; the first frame after an automatic wake-up is lost by design. The block then holds a wake state for a settle period. It does not return to normal running until software has withdrawn its request.

Software can also end sleep directly. To do so it must clear both the request and the controller's init bit. Clearing the request alone keeps the engine asleep.

Top module: `can_pd_wake_ctrl`

## Requirements
- R1: After reset, pd_ack is 0, clk_en is 1 and wake_evt is 0.
- R2: With pd_req at 1 and bus_idle at 0, the block stays pending: pd_ack stays 0 and clk_en stays 1.
- R3: In the pending state, the first clock edge that samples bus_idle at 1 sets pd_ack to 1 and clk_en to 0. Both change one cycle after that edge's inputs are applied.
- R4: If pd_req drops while pending, the block returns to running without ever raising pd_ack.
- R5: While asleep, software leaves sleep only when pd_req and init_bit are both 0. If init_bit is 1, pd_ack stays 1 and clk_en stays 0.
- R6: While asleep with wake_en at 1, a logic-0 level on rx_pin that lasts DOM_FILT synchronized samples wakes the block. With the defaults (2 sync stages, DOM_FILT 2), this happens on the fourth clock edge after rx_pin falls. On that wake, pd_ack goes to 0, clk_en goes to 1, and wake_evt is 1 for exactly one cycle.
- R7: While asleep with wake_en at 0, a dominant rx_pin level of any length is ignored: pd_ack stays 1 and wake_evt stays 0.
- R8: A dominant level shorter than DOM_FILT synchronized samples does not wake the block.
- R9: After an automatic wake-up, the block stays awake for at least WAKE_DLY cycles. It does not re-enter sleep while pd_req is still 1, even with the bus idle.
- R10: A dominant level while the block is running produces no wake_evt.
- R11: pd_ack at 1 always comes with clk_en at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | 1 | Software sleep request |
| wake_en | input | 1 | Enable for automatic wake-up on bus activity |
| init_bit | input | 1 | Controller init bit from the control register |
| bus_idle | input | 1 | Protocol engine reports no frame in progress |
| rx_pin | input | 1 | Raw CAN receive line, 0 is dominant |
| pd_ack | output | 1 | Sleep acknowledge for the status register |
| clk_en | output | 1 | Enable to the engine's clock gate |
| wake_evt | output | 1 | One-cycle pulse on automatic wake-up |

## Verification
The hardest situation to reach is the boundary of the dominant filter while the block is asleep. Only the port timing can tell a one-sample glitch apart from a qualifying dominant level, because the synchronizer adds its own delay.

The bench first reaches sleep with init_bit held high, so the block cannot slip back to running. It then drives rx_pin low for exactly one cycle, and later holds it low. It samples the outputs on the precise edge at which a wake must or must not appear.

It then keeps pd_req high with the bus idle after the wake. This exposes any premature re-entry into sleep.

// File: rtl/can_pd_pkg.sv
package can_pd_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_PD_PEND = 2'd1,
    ST_PD      = 2'd2,
    ST_WAKING  = 2'd3
  } pd_state_t;

  // saturating increment of a count toward a limit
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] lim);
    return (v >= lim) ? lim : v + 8'd1;
  endfunction

  // next state of the sleep handshake
  function automatic pd_state_t pd_next(
    input pd_state_t st,
    input logic req, input logic init, input logic idle,
    input logic wake_hit, input logic settle_done);
    pd_state_t n;
    n = st;
    case (st)
      ST_RUN:     if (req) n = ST_PD_PEND;
      ST_PD_PEND: if (!req) n = ST_RUN; else if (idle) n = ST_PD;
      ST_PD:      if (wake_hit) n = ST_WAKING; else if (!req && !init) n = ST_RUN;
      ST_WAKING:  if (settle_done && !req) n = ST_RUN;
      default:    n = ST_RUN;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/can_dom_filter.sv
module can_dom_filter
  import can_pd_pkg::*;
#(
  parameter int DOM_FILT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  output logic dom_seen
);
  localparam logic [7:0] LIM = 8'(DOM_FILT - 1);

  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    run_len <= 8'd0;
    else if (rx_s) run_len <= 8'd0;
    else           run_len <= sat_inc(run_len, LIM);

  // dominant sample now, with DOM_FILT-1 dominant samples directly before it
  assign dom_seen = !rx_s && (run_len == LIM);
endmodule

// File: rtl/can_pd_fsm.sv
module can_pd_fsm
  import can_pd_pkg::*;
#(
  parameter int WAKE_DLY = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_req,
  input  logic      wake_en,
  input  logic      init_bit,
  input  logic      bus_idle,
  input  logic      dom_seen,
  output pd_state_t st,
  output logic      wake_evt
);
  localparam logic [7:0] SLIM = 8'(WAKE_DLY - 1);

  pd_state_t  nxt;
  logic [7:0] settle;
  logic       wake_hit;
  logic       settle_done;

  assign wake_hit    = wake_en && dom_seen;
  assign settle_done = (settle == SLIM);
  assign nxt         = pd_next(st, pd_req, init_bit, bus_idle, wake_hit, settle_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_RUN;
    else        st <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 settle <= 8'd0;
    else if (st != ST_WAKING)   settle <= 8'd0;
    else                        settle <= sat_inc(settle, SLIM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wake_evt <= 1'b0;
    else        wake_evt <= (st == ST_PD) && (nxt == ST_WAKING);
endmodule

// File: rtl/can_pd_wake_ctrl.sv
module can_pd_wake_ctrl
  import can_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DOM_FILT    = 2,
  parameter int WAKE_DLY    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic wake_en,
  input  logic init_bit,
  input  logic bus_idle,
  input  logic rx_pin,
  output logic pd_ack,
  output logic clk_en,
  output logic wake_evt
);
  logic      rx_s;
  logic      dom_seen;
  pd_state_t st;

  can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_pin), .d_out(rx_s));

  can_dom_filter #(.DOM_FILT(DOM_FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .dom_seen(dom_seen));

  can_pd_fsm #(.WAKE_DLY(WAKE_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_en(wake_en),
    .init_bit(init_bit), .bus_idle(bus_idle), .dom_seen(dom_seen),
    .st(st), .wake_evt(wake_evt));

  assign pd_ack = (st == ST_PD);
  assign clk_en = (st != ST_PD);
endmodule

// File: rtl/can_pd_wake_chk.sv
module can_pd_wake_chk
  import can_pd_pkg::*;
#(
  parameter int WAKE_DLY = 4
) (
  input logic      clk,
  input logic      rst_n,
  input logic      pd_req,
  input logic      wake_en,
  input logic      init_bit,
  input logic      bus_idle,
  input logic      dom_seen,
  input pd_state_t st,
  input logic      pd_ack,
  input logic      clk_en,
  input logic      wake_evt
);
  logic [15:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hold_cnt <= 16'd0;
    else if (wake_evt) hold_cnt <= 16'd1;
    else if (hold_cnt != 16'hFFFF) hold_cnt <= hold_cnt + 16'd1;

  // R11
  ack_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> !clk_en);

  // R3
  sleep_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_ack) |-> $past(bus_idle) && $past(pd_req));

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !wake_evt);

  // R7
  wake_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> $past(wake_en) && $past(dom_seen));

  // R5
  sw_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pd_ack) && !wake_evt) |-> !$past(pd_req) && !$past(init_bit));

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) == ST_WAKING) |-> hold_cnt >= 16'(WAKE_DLY));
endmodule

bind can_pd_wake_ctrl can_pd_wake_chk #(.WAKE_DLY(WAKE_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_en(wake_en),
  .init_bit(init_bit), .bus_idle(bus_idle), .dom_seen(dom_seen), .st(st),
  .pd_ack(pd_ack), .clk_en(clk_en), .wake_evt(wake_evt));

// File: tb/sim_can_pd_wake_ctrl.sv
module sim_can_pd_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, wake_en = 1'b0, init_bit = 1'b0, bus_idle = 1'b1, rx_pin = 1'b1;
  logic pd_ack, clk_en, wake_evt;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  can_pd_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_en(wake_en),
    .init_bit(init_bit), .bus_idle(bus_idle), .rx_pin(rx_pin),
    .pd_ack(pd_ack), .clk_en(clk_en), .wake_evt(wake_evt));

  // {req, wake_en, init, idle, rx, exp_ack, exp_clk_en, exp_wake}
  localparam logic [7:0] VEC [12] = '{
    8'b00011_010,  // run
    8'b10001_010,  // R2 busy bus, pending
    8'b10001_010,  // R2 still pending
    8'b10011_100,  // R3 idle -> asleep
    8'b10111_100,  // asleep, init set
    8'b00111_100,  // R5 req low, init high: stay asleep
    8'b00011_010,  // R5 both low: run
    8'b10001_010,  // pending
    8'b00001_010,  // R4 abort
    8'b10011_010,  // pending
    8'b10011_100,  // R3 asleep
    8'b00011_010   // R5 exit
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {ack,clk_en,wake}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_sleep();
    @(negedge clk); pd_req = 1'b1; init_bit = 1'b1; bus_idle = 1'b1; rx_pin = 1'b1;
    cyc(3);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {pd_ack, clk_en, wake_evt}, 3'b010);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {pd_req, wake_en, init_bit, bus_idle, rx_pin} = VEC[i][7:3];
      @(negedge clk);
      chk($sformatf("table row %0d (R2 R3 R4 R5)", i), {pd_ack, clk_en, wake_evt}, VEC[i][2:0]);
    end

    // R7: wake disabled, long dominant ignored
    go_sleep();
    wake_en = 1'b0; rx_pin = 1'b0;
    cyc(10);
    chk("R7 dominant ignored when disabled", {pd_ack, clk_en, wake_evt}, 3'b100);
    rx_pin = 1'b1; cyc(4);

    // R8: one-cycle glitch with wake enabled
    wake_en = 1'b1; rx_pin = 1'b0;
    @(negedge clk); rx_pin = 1'b1;
    cyc(6);
    chk("R8 short dominant ignored", {pd_ack, clk_en, wake_evt}, 3'b100);

    // R6: qualifying dominant level, wake on 4th edge
    rx_pin = 1'b0;
    cyc(3);
    chk("R6 no wake before 4th edge", {pd_ack, clk_en, wake_evt}, 3'b100);
    cyc(1);
    chk("R6 wake on 4th edge", {pd_ack, clk_en, wake_evt}, 3'b011);
    cyc(1);
    chk("R6 wake pulse one cycle", {pd_ack, clk_en, wake_evt}, 3'b010);

    // R9: request still high with idle bus, no re-entry
    rx_pin = 1'b1; init_bit = 1'b0;
    cyc(12);
    chk("R9 no re-sleep while request held", {pd_ack, clk_en, wake_evt}, 3'b010);
    pd_req = 1'b0;
    cyc(3);
    chk("R9 running after request cleared", {pd_ack, clk_en, wake_evt}, 3'b010);

    // R10: dominant while running
    rx_pin = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R10 no wake event while running", {pd_ack, clk_en, wake_evt}, 3'b010);
    end
    rx_pin = 1'b1; cyc(3);

    // R11 / R3 again: ack implies gated clock, after a second sleep entry
    go_sleep();
    chk("R11 ack with clock gated", {pd_ack, clk_en}, 3'b100 >> 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule